// File: doc/BRIEF.md
# Power-Fail Guarded Byte SRAM

This block is a byte-wide static memory behind an asynchronous-style control port. Three active-low strobes (chip select, output enable, write enable) come from an external bus master. They are sampled on the system clock and decoded into read and write cycles. The array depth is a parameter: the address port is always 17 bits wide, but only the low `DEPTH_LOG2` bits select a byte. The default depth is kept small for simulation, and setting it to 17 gives the full 131,072 bytes.

A write is framed by the overlap of chip select and write enable. The window opens on the later of the two falling strobes and closes on the earlier of the two rising strobes. The byte is committed on the clock where the sampled window is first seen closed. It uses the address and data latched on the last clock the window was open. A recovery period of `REC_CYC` clocks follows each commit, and the block accepts no new cycle during it.

A read drives the output-enable pin and the data bus. Any missing condition turns the drivers off, including write enable falling during a read. A power-fail input overrides everything else. While it is asserted, the block refuses writes, aborts a window in progress, ignores the strobes and releases the bus.

Top module: `guarded_sram`

## Requirements
- R1: When sampled `ce_n`=0, `oe_n`=0, `we_n`=1 and `pwr_fail`=0 with no recovery pending, `rdata_oe` rises `SYNC_STAGES`+1 clocks after the inputs and `rdata` carries the byte stored at `addr`.
- R2: `rdata_oe` is 0 whenever `ce_n` is 1, `oe_n` is 1 or `we_n` is 0, including when `we_n` falls during an active read; `rdata` reads as 0 whenever `rdata_oe` is 0.
- R3: A write happens only while `ce_n`=0 and `we_n`=0 overlap. It stores the `wdata` and `addr` held on the last clock of the overlap, whether write enable or chip select ends the window.
- R4: While `pwr_fail` is 1, no byte is written, `rdata_oe` stays 0 and the strobes have no effect.
- R5: A window still open when `pwr_fail` rises is aborted and memory is unchanged. Strobes held low across the release of `pwr_fail` do not start a write, because a write starts only on a new opening of the window.
- R6: For `REC_CYC` clocks after a commit, window openings and read requests are ignored.
- R7: After reset, `rdata_oe` is 0 and `rdata` is 0.
- R8: Address bits at or above `DEPTH_LOG2` are ignored, so addresses that differ only there select the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| pwr_fail | input | 1 | Supply out of tolerance, active high |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driving |
| rdata_oe | output | 1 | Tri-state enable for the external data drivers |

## Verification
The assertions assume that the strobes, address and data are asynchronous to the clock but stay at each level for at least `SYNC_STAGES`+1 clocks. They also assume that address and data do not move while a write window is open. This lets a strobe change be seen as one clean transition after the sampler, with the latched address matching the one the master meant. The bench changes every input only on the falling clock edge and holds each level for several clocks. The one deliberate exception is a short pulse timed to land inside the recovery period.

// File: rtl/guarded_sram_pkg.sv
package guarded_sram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITE   = 2'd1,
    ST_RECOVER = 2'd2
  } wr_state_e;

  // bit positions of the strobe bundle through the sampler
  localparam int unsigned SB_CE = 0;
  localparam int unsigned SB_OE = 1;
  localparam int unsigned SB_WE = 2;
  localparam int unsigned SB_PF = 3;
  localparam int unsigned SB_W  = 4;

endpackage

// File: rtl/input_sampler.sv
module input_sampler #(
  parameter int unsigned          W       = 4,
  parameter int unsigned          STAGES  = 2,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
  import guarded_sram_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned DW      = 8,
  parameter int unsigned REC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          oe,
  input  logic          we,
  input  logic          pf,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req
);

  localparam int unsigned CW = (REC_CYC < 1) ? 1 : $clog2(REC_CYC + 1);

  wr_state_e      state;
  logic           win, win_q, open_edge;
  logic [CW-1:0]  rec_cnt;
  logic [AW-1:0]  lat_addr;
  logic [DW-1:0]  lat_data;

  assign win       = ce & we;
  assign open_edge = win & ~win_q & ~pf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      win_q    <= 1'b0;
      rec_cnt  <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      win_q <= win;
      unique case (state)
        ST_IDLE: begin
          if (open_edge) begin
            state    <= ST_WRITE;
            lat_addr <= addr;
            lat_data <= wdata;
          end
        end
        ST_WRITE: begin
          if (pf) begin
            state <= ST_IDLE;
          end else if (win) begin
            lat_addr <= addr;
            lat_data <= wdata;
          end else begin
            state   <= (REC_CYC == 0) ? ST_IDLE : ST_RECOVER;
            rec_cnt <= CW'(REC_CYC);
          end
        end
        ST_RECOVER: begin
          if (rec_cnt <= CW'(1)) state <= ST_IDLE;
          else                   rec_cnt <= rec_cnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_en   = (state == ST_WRITE) && !win && !pf;
  assign wr_addr = lat_addr;
  assign wr_data = lat_data;
  assign rd_req  = (state == ST_IDLE) && ce && oe && !we && !pf;

  // R6: no write may begin straight out of a recovery clock
  a_r6_recover_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER) |=> (state != ST_WRITE));

  // R3: a commit is only possible right after the window was open
  a_r3_commit_follows_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(win));

  // R5: a window open under power-fail returns to idle without committing
  a_r5_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && pf) |=> (state == ST_IDLE));

endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld  <= rd_req;
      rd_data <= rd_req ? mem[rd_addr] : '0;
    end
  end

  // R4 / R6: a read and a commit never share a clock
  a_r4_no_read_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req));

endmodule

// File: rtl/guarded_sram.sv
module guarded_sram
  import guarded_sram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DEPTH_LOG2  = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REC_CYC     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  localparam int unsigned AW = (DEPTH_LOG2 > ADDR_W) ? ADDR_W : DEPTH_LOG2;
  localparam int unsigned BW = AW + DATA_W;

  logic [SB_W-1:0] strb_raw, strb_s;
  logic [BW-1:0]   bus_raw, bus_s;
  logic            ce_s, oe_s, we_s, pf_s;
  logic [AW-1:0]   addr_s, wr_addr;
  logic [DATA_W-1:0] wdata_s, wr_data, rd_q;
  logic            wr_en, rd_req, rd_vld;

  always_comb begin
    strb_raw        = '0;
    strb_raw[SB_CE] = ~ce_n;
    strb_raw[SB_OE] = ~oe_n;
    strb_raw[SB_WE] = ~we_n;
    strb_raw[SB_PF] = pwr_fail;
  end

  assign bus_raw = {addr[AW-1:0], wdata};

  input_sampler #(.W(SB_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d_async(strb_raw), .d_sync(strb_s));

  input_sampler #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_async(bus_raw), .d_sync(bus_s));

  assign ce_s    = strb_s[SB_CE];
  assign oe_s    = strb_s[SB_OE];
  assign we_s    = strb_s[SB_WE];
  assign pf_s    = strb_s[SB_PF];
  assign addr_s  = bus_s[BW-1:DATA_W];
  assign wdata_s = bus_s[DATA_W-1:0];

  cycle_ctrl #(.AW(AW), .DW(DATA_W), .REC_CYC(REC_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ce(ce_s), .oe(oe_s), .we(we_s), .pf(pf_s),
    .addr(addr_s), .wdata(wdata_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req));

  byte_array #(.AW(AW), .DW(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(addr_s),
    .rd_vld(rd_vld), .rd_data(rd_q));

  assign rdata_oe = rd_vld;
  assign rdata    = rd_vld ? rd_q : '0;

  // R4: power-fail seen on the sampled side releases the bus next clock
  a_r4_pf_floats: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> !rdata_oe);

  // R2: drivers only on when the sampled strobes asked for a read
  a_r2_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(ce_s && oe_s && !we_s));

endmodule

// File: tb/guarded_sram_tb.sv
module guarded_sram_tb;

  localparam int unsigned AW_P   = 17;
  localparam int unsigned DW_P   = 8;
  localparam int unsigned DL2    = 10;
  localparam int unsigned SYNC   = 2;
  localparam int unsigned REC    = 3;
  localparam int unsigned DEPTH  = 1 << DL2;
  localparam int unsigned SETTLE = SYNC + 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ce_n, oe_n, we_n, pwr_fail;
  logic [AW_P-1:0] addr;
  logic [DW_P-1:0] wdata;
  logic [DW_P-1:0] rdata;
  logic            rdata_oe;

  logic [DW_P-1:0] shadow [DEPTH];
  logic [DEPTH-1:0] known;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  guarded_sram #(.ADDR_W(AW_P), .DATA_W(DW_P), .DEPTH_LOG2(DL2),
                 .SYNC_STAGES(SYNC), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_fail(pwr_fail), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int slot(input logic [AW_P-1:0] a);
    return int'(a[DL2-1:0]);
  endfunction

  // mode 0: chip select held, write enable frames the window
  // mode 1: write enable held, chip select frames the window
  task automatic do_write(input logic [AW_P-1:0] a, input logic [DW_P-1:0] d, input int mode);
    addr = a; wdata = d; oe_n = 1'b1;
    if (mode == 0) begin
      ce_n = 1'b0; idle(1); we_n = 1'b0; idle(4); we_n = 1'b1; idle(1); ce_n = 1'b1;
    end else begin
      we_n = 1'b0; idle(1); ce_n = 1'b0; idle(4); ce_n = 1'b1; idle(1); we_n = 1'b1;
    end
    idle(SETTLE + REC);
  endtask

  task automatic do_read(input logic [AW_P-1:0] a, output logic oe_o, output logic [DW_P-1:0] d_o);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    idle(SETTLE);
    oe_o = rdata_oe; d_o = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
    idle(SETTLE);
  endtask

  task automatic read_expect(input logic [AW_P-1:0] a, input string req);
    logic o; logic [DW_P-1:0] d;
    do_read(a, o, d);
    chk(o === 1'b1, {req, " drive on read"}, int'(o), 1);
    chk(d === shadow[slot(a)], {req, " read data"}, int'(d), int'(shadow[slot(a)]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; pwr_fail = 1'b0;
    addr = '0; wdata = '0;
    idle(5);
    chk(rdata_oe === 1'b0, "R7 oe after reset", int'(rdata_oe), 0);
    chk(rdata === 8'h00, "R7 data after reset", int'(rdata), 0);
    rst_n = 1'b1;
    idle(SETTLE);
  endtask

  task automatic t_write_read();
    logic [AW_P-1:0] al [4];
    logic [DW_P-1:0] dl [4];
    al[0] = 17'h00000; dl[0] = 8'hA5;
    al[1] = 17'(DEPTH - 1); dl[1] = 8'h5A;
    al[2] = 17'h00155; dl[2] = 8'hFF;
    al[3] = 17'h0002A; dl[3] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      do_write(al[i], dl[i], i % 2);
      shadow[slot(al[i])] = dl[i];
    end
    for (int i = 0; i < 4; i++) read_expect(al[i], "R1/R3");
  endtask

  task automatic t_hiz();
    logic [AW_P-1:0] a = 17'h00077;
    addr = a; wdata = 8'h3C;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; idle(SETTLE);
    chk(rdata_oe === 1'b0, "R2 oe_n high floats", int'(rdata_oe), 0);
    chk(rdata === 8'h00, "R2 idle data zero", int'(rdata), 0);
    ce_n = 1'b1; oe_n = 1'b0; idle(SETTLE);
    chk(rdata_oe === 1'b0, "R2 ce_n high floats", int'(rdata_oe), 0);
    ce_n = 1'b0; idle(SETTLE);
    chk(rdata_oe === 1'b1, "R2 read drives", int'(rdata_oe), 1);
    we_n = 1'b0; idle(SETTLE);
    chk(rdata_oe === 1'b0, "R2 we_n fall turns drivers off", int'(rdata_oe), 0);
    we_n = 1'b1; idle(1); ce_n = 1'b1; oe_n = 1'b1;
    shadow[slot(a)] = 8'h3C;
    idle(SETTLE + REC);
    read_expect(a, "R2/R3 write during read");
  endtask

  task automatic t_pf_block();
    logic [AW_P-1:0] a = 17'h00100;
    logic o; logic [DW_P-1:0] d;
    do_write(a, 8'h11, 0); shadow[slot(a)] = 8'h11;
    pwr_fail = 1'b1; idle(SETTLE);
    do_write(a, 8'hEE, 0);
    do_write(a, 8'hDD, 1);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; idle(SETTLE);
    chk(rdata_oe === 1'b0, "R4 read blocked under power-fail", int'(rdata_oe), 0);
    chk(rdata === 8'h00, "R4 bus zero under power-fail", int'(rdata), 0);
    ce_n = 1'b1; oe_n = 1'b1;
    pwr_fail = 1'b0; idle(SETTLE);
    do_read(a, o, d);
    chk(d === 8'h11, "R4 blocked writes left byte", int'(d), 8'h11);
  endtask

  task automatic t_pf_abort();
    logic [AW_P-1:0] a = 17'h00200;
    do_write(a, 8'h22, 0); shadow[slot(a)] = 8'h22;
    addr = a; wdata = 8'h99; ce_n = 1'b0; we_n = 1'b0; idle(SETTLE);
    pwr_fail = 1'b1; idle(SETTLE);
    pwr_fail = 1'b0; idle(SETTLE);   // strobes still held across release
    we_n = 1'b1; idle(1); ce_n = 1'b1; idle(SETTLE + REC);
    read_expect(a, "R5 aborted window");
  endtask

  task automatic t_recovery();
    logic [AW_P-1:0] a = 17'h00300;
    addr = a; wdata = 8'h44; oe_n = 1'b1;
    ce_n = 1'b0; idle(1); we_n = 1'b0; idle(4);
    we_n = 1'b1; idle(1);
    wdata = 8'hBB; we_n = 1'b0; idle(1);   // pulse lands inside recovery
    we_n = 1'b1; idle(1); ce_n = 1'b1;
    shadow[slot(a)] = 8'h44;
    idle(SETTLE + REC);
    read_expect(a, "R6 pulse in recovery ignored");
    do_write(a, 8'h66, 0); shadow[slot(a)] = 8'h66;
    read_expect(a, "R6 write after recovery");
  endtask

  task automatic t_alias();
    logic [AW_P-1:0] lo = 17'h00012;
    logic [AW_P-1:0] hi = lo | 17'(1 << DL2) | 17'h10000;
    do_write(hi, 8'h7E, 1); shadow[slot(hi)] = 8'h7E;
    read_expect(lo, "R8 high address bits ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    known = '0;
    t_reset();
    t_write_read();
    t_hiz();
    t_pf_block();
    t_pf_abort();
    t_recovery();
    t_alias();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule